// File: doc/BRIEF.md
# Keypad Event FIFO with Indexed Peek

This block buffers key events between a keypad scanner and a host-side reader. Each event carries a 7-bit key code and a press/release flag, and each is stored as one byte in a small circular buffer. The reader has two ways to get bytes out. A consuming read steps the head forward and returns a byte. A peek returns the byte at a chosen offset from the head and changes nothing.

The block reports its fill level on every cycle. It gives a one-cycle pulse for each stored event and a one-cycle pulse when an event finds the buffer full. After an overflow, the block latches an internal pending flag. While that flag is set, further events are discarded without comment. Only a flush clears the flag, and the same flush also empties the buffer.

Top module: `key_event_fifo`

## Requirements
- R1: After reset, level_o is 0, rd_data_o is 0x00, and both pulse outputs are low. level_o never exceeds DEPTH (16) and is wide enough to show 16.
- R2: A stored byte holds the key code in bits 6:0 and the press flag in bit 7 (1 = press, 0 = release).
- R3: An event that arrives while level_o is 16 is not stored. One cycle later, ovf_err_o pulses for exactly one cycle, and level_o stays at 16.
- R4: From an overflow until the next flush, events are ignored: level_o does not change and neither pulse output is raised.
- R5: An event that is accepted is written at head+level. In the cycle after the strobe, level_o has risen by one and kp_evt_o is high for one cycle.
- R6: A consuming read while level_o is 1 or less returns 0x00 on rd_data_o one cycle later and leaves level_o and the head unchanged.
- R7: A consuming read while level_o is 2 or more moves the head forward by one and lowers level_o by one. One cycle later, rd_data_o shows the byte at the new head.
- R8: A peek at offset n returns the byte at head+n (mod 16) when n < level_o, and 0x00 otherwise. The buffer state does not change.
- R9: A flush sets the head and level_o to zero and clears the overflow pending flag. In the same cycle it overrides any event or read, and rd_data_o keeps its value.
- R10: An event and a consuming read in the same cycle both take effect when level_o is at least 2 and below 16. level_o is then unchanged.
- R11: The head and the write position wrap modulo 16.
- R12: When a consuming read and a peek are requested in the same cycle, only the consuming read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the buffer and clear the overflow pending flag |
| evt_valid_i | input | 1 | Key event strobe |
| evt_code_i | input | 7 | Key code |
| evt_press_i | input | 1 | 1 = press, 0 = release |
| pop_i | input | 1 | Consuming read request |
| peek_i | input | 1 | Non-destructive read request |
| peek_off_i | input | 5 | Peek byte offset from head |
| rd_data_o | output | 8 | Registered read result |
| level_o | output | 5 | Fill level, 0..16 |
| kp_evt_o | output | 1 | One-cycle pulse per stored event |
| ovf_err_o | output | 1 | One-cycle pulse on overflow |

## Verification
Every result is registered. The level, both pulses and the read byte all appear on the first rising edge after the cycle that holds the strobe. The bench drives inputs on the falling edge and, for each operation, compares level_o and the pulses on the next falling edge. It also places the expected read byte in a queue at the intervening rising edge, and a separate monitor pops that byte and compares it against rd_data_o on the same falling edge. That falling edge is exactly one register stage after the strobe.

// File: rtl/kfifo_pkg.sv
package kfifo_pkg;
  localparam int unsigned KEY_CODE_W = 7;
  localparam int unsigned ENTRY_W    = KEY_CODE_W + 1;

  typedef struct packed {
    logic                  press;
    logic [KEY_CODE_W-1:0] code;
  } kev_t;

  function automatic kev_t pack_kev(input logic press, input logic [KEY_CODE_W-1:0] code);
    kev_t e;
    e.press = press;
    e.code  = code;
    return e;
  endfunction
endpackage

// File: rtl/kfifo_store.sv
module kfifo_store
  import kfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  kev_t             wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output kev_t             rd_data_o
);
  kev_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == PTR_W'(g))) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/kfifo_ctrl.sv
module kfifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  output logic [PTR_W-1:0] rptr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             kp_evt_o,
  output logic             ovf_err_o
);
  logic [PTR_W-1:0] rptr_q;
  logic [LVL_W-1:0] level_q;
  logic             pend_q, kp_q, ovf_q;
  logic             full, evt_live, accept, overflow, pop_go;

  assign full     = (level_q == LVL_W'(DEPTH));
  assign evt_live = push_req_i && !flush_i && !pend_q;
  assign accept   = evt_live && !full;
  assign overflow = evt_live && full;
  assign pop_go   = pop_req_i && !flush_i && (level_q > LVL_W'(1));

  assign wr_en_o  = accept;
  assign wr_idx_o = rptr_q + level_q[PTR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      level_q <= '0;
      pend_q  <= 1'b0;
      kp_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      kp_q  <= accept;
      ovf_q <= overflow;
      if (flush_i) begin
        rptr_q  <= '0;
        level_q <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (pop_go) rptr_q <= rptr_q + PTR_W'(1);
        level_q <= level_q + LVL_W'(accept) - LVL_W'(pop_go);
        if (overflow) pend_q <= 1'b1;
      end
    end
  end

  assign rptr_o    = rptr_q;
  assign level_o   = level_q;
  assign kp_evt_o  = kp_q;
  assign ovf_err_o = ovf_q;

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && !flush_i && !pop_req_i && full) |=> (level_q == LVL_W'(DEPTH)) && !kp_q);
  assert_pending_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !flush_i && !pop_req_i) |=> $stable(level_q) && !kp_q && !ovf_q);
  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0) && (rptr_q == '0) && !kp_q && !ovf_q);
  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kp_q, ovf_q}));
endmodule

// File: rtl/kfifo_rdport.sv
module kfifo_rdport
  import kfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic             peek_i,
  input  logic [LVL_W-1:0] peek_off_i,
  input  logic [PTR_W-1:0] rptr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [PTR_W-1:0] rd_idx_o,
  input  kev_t             entry_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  logic               hit, rd_go;
  logic [PTR_W-1:0]   step;
  logic [ENTRY_W-1:0] data_q;

  // consuming read looks one past head: head itself is only reachable by peek
  assign step     = pop_i ? PTR_W'(1) : peek_off_i[PTR_W-1:0];
  assign rd_idx_o = rptr_i + step;
  assign hit      = pop_i ? (level_i > LVL_W'(1)) : (peek_off_i < level_i);
  assign rd_go    = !flush_i && (pop_i || peek_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (rd_go) data_q <= hit ? entry_i : '0;
  end

  assign rd_data_o = data_q;

  assert_pop_low_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i && (level_i <= LVL_W'(1))) |=> (data_q == '0));
  assert_peek_miss_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_i && !pop_i && !flush_i && (peek_off_i >= level_i)) |=> (data_q == '0));
  assert_flush_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> $stable(data_q));
endmodule

// File: rtl/key_event_fifo.sv
module key_event_fifo
  import kfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  evt_valid_i,
  input  logic [KEY_CODE_W-1:0] evt_code_i,
  input  logic                  evt_press_i,
  input  logic                  pop_i,
  input  logic                  peek_i,
  input  logic [LVL_W-1:0]      peek_off_i,
  output logic [ENTRY_W-1:0]    rd_data_o,
  output logic [LVL_W-1:0]      level_o,
  output logic                  kp_evt_o,
  output logic                  ovf_err_o
);
  logic [PTR_W-1:0] rptr, wr_idx, rd_idx;
  logic             wr_en;
  kev_t             rd_entry;

  kfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .flush_i,
    .push_req_i (evt_valid_i),
    .pop_req_i  (pop_i),
    .rptr_o     (rptr),
    .level_o    (level_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .kp_evt_o   (kp_evt_o),
    .ovf_err_o  (ovf_err_o)
  );

  kfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (pack_kev(evt_press_i, evt_code_i)),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_entry)
  );

  kfifo_rdport #(.DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni, .flush_i, .pop_i, .peek_i, .peek_off_i,
    .rptr_i    (rptr),
    .level_i   (level_o),
    .rd_idx_o  (rd_idx),
    .entry_i   (rd_entry),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/key_event_fifo_tb.sv
`timescale 1ns/1ps
module key_event_fifo_tb;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       flush_i = 0, evt_valid_i = 0, evt_press_i = 0, pop_i = 0, peek_i = 0;
  logic [6:0] evt_code_i = '0;
  logic [4:0] peek_off_i = '0;
  logic [7:0] rd_data_o;
  logic [4:0] level_o;
  logic       kp_evt_o, ovf_err_o;

  int checks = 0, errors = 0;

  key_event_fifo #(.DEPTH(DEPTH)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  logic [7:0] mem [DEPTH];
  int rp = 0, lv = 0;
  bit pend = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         rd_due = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rd_due) begin
      rd_due = 0;
      chk(tag_q.pop_front(), "rd_data", rd_data_o, exp_q.pop_front());
    end
  end

  task automatic cyc(string tag, bit fl, bit v, logic [6:0] c, bit p,
                     bit po, bit pk, logic [4:0] o);
    int nrp = rp, nlv = lv;
    bit ekp = 0, eovf = 0, rd = 0;
    logic [7:0] erd = '0;
    if (fl) begin
      nrp = 0; nlv = 0; pend = 0;
    end else begin
      if (po) begin
        rd = 1;
        if (lv > 1) begin erd = mem[(rp + 1) % DEPTH]; nrp = (rp + 1) % DEPTH; nlv--; end
      end else if (pk) begin
        rd = 1;
        erd = (int'(o) < lv) ? mem[(rp + int'(o)) % DEPTH] : 8'h00;
      end
      if (v && !pend) begin
        if (lv == DEPTH) begin eovf = 1; pend = 1; end
        else begin mem[(rp + lv) % DEPTH] = {p, c}; nlv++; ekp = 1; end
      end
    end
    rp = nrp; lv = nlv;
    flush_i = fl; evt_valid_i = v; evt_code_i = c; evt_press_i = p;
    pop_i = po; peek_i = pk; peek_off_i = o;
    @(posedge clk_i);
    if (rd) begin exp_q.push_back(erd); tag_q.push_back(tag); rd_due = 1; end
    @(negedge clk_i);
    chk(tag, "level", level_o, lv);
    chk(tag, "kp_evt", kp_evt_o, ekp);
    chk(tag, "ovf_err", ovf_err_o, eovf);
    flush_i = 0; evt_valid_i = 0; pop_i = 0; peek_i = 0;
  endtask

  task automatic push(string tag, logic [6:0] c, bit p);
    cyc(tag, 0, 1, c, p, 0, 0, '0);
  endtask
  task automatic pop(string tag);
    cyc(tag, 0, 0, '0, 0, 1, 0, '0);
  endtask
  task automatic peek(string tag, logic [4:0] o);
    cyc(tag, 0, 0, '0, 0, 0, 1, o);
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "reset level", level_o, 0);
    chk("R1", "reset rd_data", rd_data_o, 0);
    chk("R1", "reset kp", kp_evt_o, 0);
    chk("R1", "reset ovf", ovf_err_o, 0);

    // R6: empty pop returns zero
    pop("R6");
    push("R5", 7'h3c, 1);
    push("R5", 7'h11, 0);
    push("R5", 7'h7f, 1);
    // R2: encoding seen through peek, R8 in-range and beyond level
    peek("R2", 5'd0);
    peek("R2", 5'd1);
    peek("R8", 5'd2);
    peek("R8", 5'd3);
    peek("R8", 5'd20);
    // R12: pop wins over peek
    cyc("R12", 0, 0, '0, 0, 1, 1, 5'd0);
    pop("R7");
    pop("R6");
    pop("R6");
    // R9: flush overrides event and read in the same cycle
    cyc("R9", 1, 1, 7'h05, 1, 1, 0, '0);
    // fill to full, then overflow
    for (int i = 0; i < DEPTH; i++) push("R5", 7'(i + 8'h20), 1'(i));
    push("R3", 7'h44, 1);
    push("R4", 7'h45, 0);
    pop("R7");
    push("R4", 7'h46, 1);
    peek("R8", 5'd14);
    cyc("R9", 1, 0, '0, 0, 0, 0, '0);
    push("R9", 7'h01, 1);
    push("R5", 7'h02, 0);
    push("R5", 7'h03, 1);
    // R10 / R11: simultaneous push and pop walks the pointers round
    for (int i = 0; i < 40; i++) cyc("R10", 0, 1, 7'(i + 8'h50), 1'(i % 2), 1, 0, '0);
    for (int i = 0; i < 3; i++) peek("R11", 5'(i));
    for (int i = 0; i < 3; i++) pop("R11");
    @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule